// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block collects reset requests from ten sources and turns them into two reset levels for the rest of the chip. A hard reset reaches the system-level logic: memory control, protection, interrupt routing and parallel I/O. A soft reset reaches only internal logic and leaves the system configuration intact. Every hard reset also asserts the soft level. All request pins are active low and asynchronous. Each pin passes through a two-flop synchronizer before the logic classifies it.

A power-on input, also active low, forces the power-on state. It asserts both outputs at once, without waiting for a clock edge. The state lasts until two things are true: the power-on pin has been released and the PLL reports lock. While the block is in this state it samples a 3-bit clock-mode word on every cycle. It then holds the last sampled value for the clock logic. After the last request goes away, both outputs stay asserted for a fixed number of further clock cycles. A readable status word records which source or sources started the most recent reset.

Top module: `reset_hub`

## Requirements
- R1: While `porN` is low, `hardRstN` and `softRstN` are both 0 and `status` equals 10'h001, with bit 0 marking power-on.
- R2: After `porN` rises, both outputs stay asserted until `pllLock` is also high. If lock rises at a negedge after `porN` is already synchronized high, the outputs are still asserted STRETCH+2 edges later and released one edge after that.
- R3: In the power-on state `cfgHeld` follows `modeCfg` with a delay of one edge. Once that state has been left, `cfgHeld` keeps its value.
- R4: The hard sources assert both outputs. Their `reqN` bits are 0 (external hard), 2 (clock switch), 3 (watchdog), 4 (checkstop), 5 (debug hard) and 7 (test-port reset). Loss of lock is also a hard source.
- R5: The soft sources, `reqN` bit 1 (external soft) and bit 6 (debug soft), assert `softRstN` only. `hardRstN` stays 1.
- R6: A request is released at a negedge. The affected outputs are still asserted STRETCH+1 rising edges later and are released at the next edge.
- R7: If `pllLock` falls after the power-on state has been left, a hard reset follows and the status word becomes 10'h008 (bit 3).
- R8: A new reset event is a cycle with an active source after a cycle with none. On each new event the status word is replaced by the set of active sources. The status bits are: 1 external hard, 2 external soft, 4 clock switch, 5 watchdog, 6 checkstop, 7 debug hard, 8 debug soft, 9 test-port. Sources that arrive together all set their bits. A source that joins a reset already in progress leaves the status word unchanged.
- R9: A request driven low at a negedge shows at the outputs after the third rising edge and not before.
- R10: A checker, parameterized by a minimum cycle count (default 100000), flags any power-on pulse shorter than that count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| porN | input | 1 | Power-on reset, active low, asynchronous |
| pllLock | input | 1 | PLL lock indication, high when locked |
| reqN | input | 8 | Active-low reset request pins, asynchronous |
| modeCfg | input | CFG_W | Clock-mode configuration word |
| hardRstN | output | 1 | Hard reset to system-level logic, active low |
| softRstN | output | 1 | Soft reset to internal logic, active low |
| cfgHeld | output | CFG_W | Clock-mode word latched in the power-on state |
| status | output | 10 | One bit per source, cause of the latest reset |

## Verification
Some internal faults show at the ports only after a delay. A wrong count in the stretch counter shows up one or more edges later as an early or late release, so the bench measures every release to the exact edge. A wrong source class shows within three edges of a request: `hardRstN` falls when it should not, or fails to fall when it should. A corrupted cause register stays hidden until `status` is read. For that reason the status word is checked after every reset, including the case where a request joins a reset already running. A configuration latch that goes on sampling after power-on is found by changing `modeCfg` later and reading `cfgHeld` again.

// File: rtl/reset_hub_pkg.sv
package reset_hub_pkg;
  localparam int NUM_REQ = 8;
  localparam int NUM_SRC = 10;

  // status bit positions; software decodes these
  localparam int SRC_POR      = 0;
  localparam int SRC_EXT_HARD = 1;
  localparam int SRC_EXT_SOFT = 2;
  localparam int SRC_LOCK     = 3;
  localparam int SRC_CLK_SW   = 4;
  localparam int SRC_WDOG     = 5;
  localparam int SRC_CHKSTOP  = 6;
  localparam int SRC_DBG_HARD = 7;
  localparam int SRC_DBG_SOFT = 8;
  localparam int SRC_JTAG     = 9;

  localparam logic [NUM_SRC-1:0] SOFT_ONLY_MASK =
    (NUM_SRC'(1) << SRC_EXT_SOFT) | (NUM_SRC'(1) << SRC_DBG_SOFT);
  localparam logic [NUM_SRC-1:0] HARD_MASK = ~SOFT_ONLY_MASK;
  localparam logic [NUM_SRC-1:0] POR_STATUS = NUM_SRC'(1) << SRC_POR;

  typedef enum logic [0:0] {ST_POWERON, ST_RUN} rstState_t;

  typedef struct packed {
    logic sampleCfg;
    logic loadHard;
    logic loadSoft;
    logic captureCause;
  } ctrlStrobe_t;

  // request pin index -> status bit
  function automatic int reqToSrc(input int idx);
    case (idx)
      0:       return SRC_EXT_HARD;
      1:       return SRC_EXT_SOFT;
      2:       return SRC_CLK_SW;
      3:       return SRC_WDOG;
      4:       return SRC_CHKSTOP;
      5:       return SRC_DBG_HARD;
      6:       return SRC_DBG_SOFT;
      default: return SRC_JTAG;
    endcase
  endfunction
endpackage

// File: rtl/reset_hub_sync.sv
module reset_hub_sync #(
  parameter int   WIDTH   = 1,
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic             clk,
  input  logic             arstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES:0][WIDTH-1:0] chain;

  assign chain[0] = din;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge arstN) begin
      if (!arstN) chain[s+1] <= {WIDTH{RST_VAL}};
      else        chain[s+1] <= chain[s];
    end
  end

  assign dout = chain[STAGES];
endmodule

// File: rtl/reset_hub_stretch.sv
module reset_hub_stretch #(
  parameter int STRETCH_CYC = 16
) (
  input  logic clk,
  input  logic arstN,
  input  logic load,
  output logic active
);
  localparam int CNT_W = $clog2(STRETCH_CYC + 2);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(STRETCH_CYC);

  logic [CNT_W-1:0] cntQ, cntD;
  logic activeQ;

  always_comb begin
    if (load)            cntD = CNT_LOAD;
    else if (cntQ != '0) cntD = cntQ - 1'b1;
    else                 cntD = '0;
  end

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) begin
      cntQ    <= CNT_LOAD;
      activeQ <= 1'b1;
    end else begin
      cntQ    <= cntD;
      activeQ <= load || (cntD != '0);
    end
  end

  assign active = activeQ;
endmodule

// File: rtl/reset_hub_ctrl.sv
module reset_hub_ctrl import reset_hub_pkg::*; (
  input  logic               clk,
  input  logic               porN,
  input  logic               porSyncN,
  input  logic               lockSync,
  input  logic [NUM_REQ-1:0] reqSyncN,
  output ctrlStrobe_t        strobe,
  output logic [NUM_SRC-1:0] activeSrc,
  output logic               inPor
);
  rstState_t stateQ, stateD;
  logic anyActPrevQ;
  logic anyAct;

  always_comb begin
    inPor     = (stateQ == ST_POWERON);
    activeSrc = '0;
    activeSrc[SRC_POR]  = inPor;
    activeSrc[SRC_LOCK] = !inPor && !lockSync;
    for (int i = 0; i < NUM_REQ; i++) begin
      activeSrc[reqToSrc(i)] = ~reqSyncN[i];
    end
    anyAct = |activeSrc;

    stateD = stateQ;
    if (inPor && porSyncN && lockSync) stateD = ST_RUN;

    strobe.sampleCfg    = inPor;
    strobe.loadHard     = |(activeSrc & HARD_MASK);
    strobe.loadSoft     = anyAct;
    strobe.captureCause = anyAct && !anyActPrevQ;
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      stateQ      <= ST_POWERON;
      anyActPrevQ <= 1'b1;
    end else begin
      stateQ      <= stateD;
      anyActPrevQ <= anyAct;
    end
  end
endmodule

// File: rtl/reset_hub_dp.sv
module reset_hub_dp import reset_hub_pkg::*; #(
  parameter int CFG_W       = 3,
  parameter int STRETCH_CYC = 16
) (
  input  logic               clk,
  input  logic               porN,
  input  ctrlStrobe_t        strobe,
  input  logic [NUM_SRC-1:0] activeSrc,
  input  logic [CFG_W-1:0]   modeCfg,
  output logic               hardOn,
  output logic               softOn,
  output logic [CFG_W-1:0]   cfgHeld,
  output logic [NUM_SRC-1:0] status
);
  logic [NUM_SRC-1:0] statusQ;
  logic [CFG_W-1:0]   cfgQ;

  reset_hub_stretch #(.STRETCH_CYC(STRETCH_CYC)) u_hardStretch (
    .clk(clk), .arstN(porN), .load(strobe.loadHard), .active(hardOn)
  );

  reset_hub_stretch #(.STRETCH_CYC(STRETCH_CYC)) u_softStretch (
    .clk(clk), .arstN(porN), .load(strobe.loadSoft), .active(softOn)
  );

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)                    statusQ <= POR_STATUS;
    else if (strobe.captureCause) statusQ <= activeSrc;
  end

  // no reset: sampled on every edge of the power-on state
  always_ff @(posedge clk) begin
    if (strobe.sampleCfg) cfgQ <= modeCfg;
  end

  assign status  = statusQ;
  assign cfgHeld = cfgQ;
endmodule

// File: rtl/reset_hub.sv
module reset_hub import reset_hub_pkg::*; #(
  parameter int CFG_W       = 3,
  parameter int STRETCH_CYC = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               porN,
  input  logic               pllLock,
  input  logic [NUM_REQ-1:0] reqN,
  input  logic [CFG_W-1:0]   modeCfg,
  output logic               hardRstN,
  output logic               softRstN,
  output logic [CFG_W-1:0]   cfgHeld,
  output logic [NUM_SRC-1:0] status
);
  logic               porSyncN;
  logic               lockSync;
  logic [NUM_REQ-1:0] reqSyncN;
  ctrlStrobe_t        ctrlStrobe;
  logic [NUM_SRC-1:0] activeSrc;
  logic               inPor;
  logic               hardOn;
  logic               softOn;

  reset_hub_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_porSync (
    .clk(clk), .arstN(porN), .din(1'b1), .dout(porSyncN)
  );

  reset_hub_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_lockSync (
    .clk(clk), .arstN(porN), .din(pllLock), .dout(lockSync)
  );

  reset_hub_sync #(.WIDTH(NUM_REQ), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_reqSync (
    .clk(clk), .arstN(porN), .din(reqN), .dout(reqSyncN)
  );

  reset_hub_ctrl u_ctrl (
    .clk(clk), .porN(porN), .porSyncN(porSyncN), .lockSync(lockSync),
    .reqSyncN(reqSyncN), .strobe(ctrlStrobe), .activeSrc(activeSrc), .inPor(inPor)
  );

  reset_hub_dp #(.CFG_W(CFG_W), .STRETCH_CYC(STRETCH_CYC)) u_dp (
    .clk(clk), .porN(porN), .strobe(ctrlStrobe), .activeSrc(activeSrc),
    .modeCfg(modeCfg), .hardOn(hardOn), .softOn(softOn),
    .cfgHeld(cfgHeld), .status(status)
  );

  assign hardRstN = ~hardOn;
  assign softRstN = ~softOn;
endmodule

// File: rtl/reset_hub_chk.sv
module reset_hub_chk import reset_hub_pkg::*; #(
  parameter int CFG_W       = 3,
  parameter int POR_MIN_CYC = 100000
) (
  input logic               clk,
  input logic               porN,
  input logic               hardRstN,
  input logic               softRstN,
  input logic [CFG_W-1:0]   cfgHeld,
  input logic [NUM_SRC-1:0] status,
  input logic               inPor,
  input ctrlStrobe_t        strobe
);
  localparam int LCW = $clog2(POR_MIN_CYC + 2);
  localparam logic [LCW-1:0] LOW_MAX = LCW'(POR_MIN_CYC);

  logic           porPrevQ = 1'b1;
  logic [LCW-1:0] lowCntQ  = '0;

  always_ff @(posedge clk) begin
    porPrevQ <= porN;
    if (porN)                   lowCntQ <= '0;
    else if (lowCntQ < LOW_MAX) lowCntQ <= lowCntQ + 1'b1;
  end

  // R10: power-on pulse held for the minimum count
  p_por_width_r10: assert property (@(posedge clk)
    (porN && !porPrevQ) |-> (lowCntQ >= LOW_MAX));

  p_hard_implies_soft_r4: assert property (@(posedge clk) disable iff (!porN)
    !hardRstN |-> !softRstN);

  p_por_holds_r2: assert property (@(posedge clk) disable iff (!porN)
    inPor |=> (!hardRstN && !softRstN));

  p_cfg_frozen_r3: assert property (@(posedge clk) disable iff (!porN)
    !inPor |=> $stable(cfgHeld));

  p_status_nonempty_r8: assert property (@(posedge clk) disable iff (!porN)
    status != '0);

  p_hard_needs_cause_r4: assert property (@(posedge clk) disable iff (!porN)
    $fell(hardRstN) |-> $past(strobe.loadHard));

  p_soft_keeps_hard_r5: assert property (@(posedge clk) disable iff (!porN)
    (strobe.loadSoft && !strobe.loadHard && hardRstN) |=> hardRstN);
endmodule

bind reset_hub reset_hub_chk #(.CFG_W(CFG_W)) u_chk (
  .clk(clk), .porN(porN), .hardRstN(hardRstN), .softRstN(softRstN),
  .cfgHeld(cfgHeld), .status(status), .inPor(inPor), .strobe(ctrlStrobe)
);

// File: tb/reset_hub_tb.sv
module reset_hub_tb;
  localparam int CLK_PERIOD = 10;
  localparam int STRETCH    = 16;
  localparam int POR_CYC    = 100005;
  localparam int WDOG_CYC   = 180000;

  logic       clk = 1'b0;
  logic       porN;
  logic       pllLock;
  logic [7:0] reqN;
  logic [2:0] modeCfg;
  logic       hardRstN, softRstN;
  logic [2:0] cfgHeld;
  logic [9:0] status;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reset_hub #(.CFG_W(3), .STRETCH_CYC(STRETCH), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .porN(porN), .pllLock(pllLock), .reqN(reqN), .modeCfg(modeCfg),
    .hardRstN(hardRstN), .softRstN(softRstN), .cfgHeld(cfgHeld), .status(status)
  );

  task automatic expectEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // status word expected for a set of request pins pulled together (R8)
  function automatic logic [9:0] expStatus(input logic [7:0] r);
    return {r[7:2], 1'b0, r[1:0], 1'b0};
  endfunction

  // hard class: every pin except 1 and 6 (R4, R5)
  function automatic logic expHard(input logic [7:0] r);
    return |(r & 8'b1011_1101);
  endfunction

  // R6: release at a negedge, check the last asserted edge and the release edge
  task automatic checkRelease(input string tag, input int extra, input logic hardExp);
    repeat (STRETCH + 1 + extra) @(posedge clk);
    #1;
    expectEq({tag, " soft held"}, 32'(softRstN), 32'd0);
    expectEq({tag, " hard held"}, 32'(hardRstN), 32'(!hardExp));
    @(posedge clk);
    #1;
    expectEq({tag, " soft released"}, 32'(softRstN), 32'd1);
    expectEq({tag, " hard released"}, 32'(hardRstN), 32'd1);
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == WDOG_CYC && !finished) begin
      bad++;
      total++;
      $display("FAIL watchdog R1..R10 actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned seedInit;
    logic [7:0] r;
    int hold;
    int porLow;
    seedInit = $urandom(32'd20240611);
    porN = 1'b0; pllLock = 1'b0; reqN = 8'hFF; modeCfg = 3'd6;

    repeat (5) @(posedge clk);
    #1;
    expectEq("R1 hard in power-on", 32'(hardRstN), 32'd0);
    expectEq("R1 soft in power-on", 32'(softRstN), 32'd0);
    expectEq("R1 status in power-on", 32'(status), 32'h001);
    expectEq("R3 cfg sampled in power-on", 32'(cfgHeld), 32'd6);

    repeat (POR_CYC) @(posedge clk);
    porLow = cycles;
    expectEq("R10 power-on pulse long enough", 32'(porLow >= 100000), 32'd1);
    @(negedge clk) porN = 1'b1;

    repeat (20) @(posedge clk);
    #1;
    expectEq("R2 waits for lock hard", 32'(hardRstN), 32'd0);
    expectEq("R2 waits for lock soft", 32'(softRstN), 32'd0);
    @(negedge clk) modeCfg = 3'd5;
    repeat (2) @(posedge clk);
    #1;
    expectEq("R3 cfg follows in power-on", 32'(cfgHeld), 32'd5);

    @(negedge clk) pllLock = 1'b1;
    checkRelease("R2 lock exit", 1, 1'b1);
    expectEq("R1 status after exit", 32'(status), 32'h001);
    @(negedge clk) modeCfg = 3'd2;
    repeat (4) @(posedge clk);
    #1;
    expectEq("R3 cfg frozen", 32'(cfgHeld), 32'd5);

    // R5 soft only
    @(negedge clk) reqN = ~8'h02;
    repeat (3) @(posedge clk);
    #1;
    expectEq("R5 soft asserted", 32'(softRstN), 32'd0);
    expectEq("R5 hard untouched", 32'(hardRstN), 32'd1);
    repeat (3) @(posedge clk);
    @(negedge clk) reqN = 8'hFF;
    checkRelease("R6 soft stretch", 0, 1'b0);
    expectEq("R8 soft cause", 32'(status), 32'h004);

    // R9 synchronizer latency
    @(negedge clk) reqN = ~8'h10;
    repeat (2) @(posedge clk);
    #1;
    expectEq("R9 not before third edge", 32'(hardRstN), 32'd1);
    @(posedge clk);
    #1;
    expectEq("R9 at third edge", 32'(hardRstN), 32'd0);
    @(negedge clk) reqN = 8'hFF;
    checkRelease("R6 hard stretch", 0, 1'b1);
    expectEq("R8 checkstop cause", 32'(status), 32'h040);

    // R8 join: a later source does not overwrite the cause
    @(negedge clk) reqN = ~8'h08;
    repeat (5) @(posedge clk);
    @(negedge clk) reqN = ~8'h09;
    repeat (5) @(posedge clk);
    @(negedge clk) reqN = 8'hFF;
    checkRelease("R6 joined", 0, 1'b1);
    expectEq("R8 join keeps first cause", 32'(status), 32'h020);

    // R7 loss of lock
    @(negedge clk) pllLock = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    expectEq("R7 hard on lock loss", 32'(hardRstN), 32'd0);
    expectEq("R7 lock cause", 32'(status), 32'h008);
    repeat (4) @(posedge clk);
    @(negedge clk) pllLock = 1'b1;
    checkRelease("R7 relock", 0, 1'b1);

    // R4/R5/R8 random source sets
    for (int it = 0; it < 30; it++) begin
      r = 8'($urandom);
      if (r == 8'h00) r = 8'h80;
      hold = 3 + int'($urandom % 6);
      @(negedge clk) reqN = ~r;
      repeat (3) @(posedge clk);
      #1;
      expectEq("R4 soft level", 32'(softRstN), 32'd0);
      expectEq("R4 hard class", 32'(hardRstN), 32'(!expHard(r)));
      repeat (hold - 3) @(posedge clk);
      @(negedge clk) reqN = 8'hFF;
      checkRelease("R6 random", 0, expHard(r));
      expectEq("R8 random cause", 32'(status), 32'(expStatus(r)));
      repeat (2 + int'($urandom % 3)) @(posedge clk);
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule